// File: doc/BRIEF.md
# Password Retry Lockout Controller

This block counts failed password attempts for a password-guarded storage device and enforces a lockout once the tolerance is used up. The command front end presents single-cycle strobes: one when a read or write password compare fails, one when such a compare succeeds, one when a reset-device command arrives with the correct reset password, and one when a reset-password command arrives. The controller holds the failure count, the lock flag and the pulse outputs. Password storage and memory clearing are done in the blocks that receive its outputs.

Up to `MAX_TRIES` wrong passwords of any kind are tolerated. One more miss overflows the counter. The block then raises `locked` and pulses `clr_arrays` once. While `locked` is high, the compare logic must fail every read or write password. The stored passwords are left alone. Only a reset-device command qualified by the reset password clears the lock. The same command before overflow only zeroes the count. A reset-password command wipes both arrays and tells the password store to zero every password.

All outputs are registered. A strobe sampled at a rising edge is reflected on the outputs right after that edge.

Top module: `pw_lockout_ctrl`

## Requirements
- R1: While unlocked, a `pw_miss` strobe with no `pw_hit` and no `rdev_ok` in the same cycle increments `tries` by one after the edge, as long as `tries` is below `MAX_TRIES`.
- R2: While unlocked, a `pw_hit` strobe with no `rdev_ok` sets `tries` to 0 and raises `grant` for exactly the following cycle.
- R3: While unlocked, a counted miss that arrives when `tries` equals `MAX_TRIES` sets `locked` to 1 and pulses `clr_arrays` for one cycle after the edge. `tries` stays at `MAX_TRIES` and `zero_pw` stays 0, because overflow does not touch the passwords.
- R4: While `locked` is 1, `pw_hit` gives no `grant` and leaves `tries` unchanged.
- R5: An `rdev_ok` strobe while unlocked sets `tries` to 0 and produces no `clr_arrays` pulse. `locked` stays 0.
- R6: An `rdev_ok` strobe while locked clears `locked` and `tries`. After it, misses are counted again from 0.
- R7: An `rpw_ok` strobe pulses both `clr_arrays` and `zero_pw` for the following cycle. It leaves `tries` and `locked` unchanged.
- R8: While `locked` is 1, misses leave `tries` unchanged. `clr_arrays` pulses exactly once per overflow, so while locked it rises only on `rpw_ok`.
- R9: After `rst_n` is low, `tries`, `locked`, `clr_arrays`, `zero_pw` and `grant` are all 0.
- R10: Among strobes in the same cycle, `rdev_ok` wins over `pw_hit`, and `pw_hit` wins over `pw_miss`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pw_miss | input | 1 | Read/write password compare failed (one-cycle strobe) |
| pw_hit | input | 1 | Read/write password compare succeeded (one-cycle strobe) |
| rdev_ok | input | 1 | Reset-device command with correct reset password |
| rpw_ok | input | 1 | Reset-password command accepted |
| tries | output | $clog2(MAX_TRIES+1) | Current failed-attempt count |
| locked | output | 1 | Lockout active: force all read/write compares to fail |
| clr_arrays | output | 1 | One-cycle request to clear all memory arrays |
| zero_pw | output | 1 | One-cycle request to set all passwords to zero |
| grant | output | 1 | One-cycle access grant after an accepted password |

## Verification
The bench builds the block with the default `MAX_TRIES` of 8, which gives a 4-bit counter. With this value the full tolerance and the overflow miss are reached within a few dozen cycles. The saturated count value 8 also exercises the top bit of the counter, so the tolerance boundary is checked at the count value that sets that bit. The stimulus covers the lock interval, its release by the reset-device command, and the strobes that collide in one cycle.

// File: rtl/pw_lockout_pkg.sv
package pw_lockout_pkg;

  typedef enum logic [1:0] {
    EV_NONE    = 2'd0,
    EV_HIT     = 2'd1,
    EV_MISS    = 2'd2,
    EV_RECOVER = 2'd3
  } lock_ev_e;

  function automatic int unsigned tries_width(input int unsigned max_tries);
    return $clog2(max_tries + 1);
  endfunction

  // Reset-device command outranks a good compare, which outranks a bad one.
  // While locked, compare results are not acted on at all.
  function automatic lock_ev_e classify(input logic miss, input logic hit,
                                        input logic recover, input logic lk);
    if (recover)  return EV_RECOVER;
    if (lk)       return EV_NONE;
    if (hit)      return EV_HIT;
    if (miss)     return EV_MISS;
    return EV_NONE;
  endfunction

endpackage

// File: rtl/lockout_counter.sv
module lockout_counter #(
  parameter int unsigned MAX_TRIES = 8,
  parameter int unsigned CW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          clear,
  output logic [CW-1:0] count,
  output logic          at_limit
);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_TRIES);

  logic [CW-1:0] cnt_q;

  assign at_limit = (cnt_q == LIMIT);
  assign count    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (clear)               cnt_q <= '0;
    else if (step && !at_limit)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lockout_flags.sv
module lockout_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_lock,
  input  logic release_lock,
  input  logic wipe_req,
  input  logic zero_req,
  input  logic grant_req,
  output logic locked,
  output logic clr_arrays,
  output logic zero_pw,
  output logic grant
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked     <= 1'b0;
      clr_arrays <= 1'b0;
      zero_pw    <= 1'b0;
      grant      <= 1'b0;
    end else begin
      if (set_lock)          locked <= 1'b1;
      else if (release_lock) locked <= 1'b0;
      clr_arrays <= set_lock | wipe_req;
      zero_pw    <= zero_req;
      grant      <= grant_req;
    end
  end
endmodule

// File: rtl/pw_lockout_ctrl.sv
module pw_lockout_ctrl
  import pw_lockout_pkg::*;
#(
  parameter int unsigned MAX_TRIES = 8,
  localparam int unsigned CW = tries_width(MAX_TRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pw_miss,
  input  logic          pw_hit,
  input  logic          rdev_ok,
  input  logic          rpw_ok,
  output logic [CW-1:0] tries,
  output logic          locked,
  output logic          clr_arrays,
  output logic          zero_pw,
  output logic          grant
);
  lock_ev_e ev;
  logic     at_limit;
  logic     ev_hit, ev_miss, ev_recover, ev_overflow, ev_count;

  assign ev          = classify(pw_miss, pw_hit, rdev_ok, locked);
  assign ev_hit      = (ev == EV_HIT);
  assign ev_miss     = (ev == EV_MISS);
  assign ev_recover  = (ev == EV_RECOVER);
  assign ev_overflow = ev_miss & at_limit;
  assign ev_count    = ev_miss & ~at_limit;

  lockout_counter #(.MAX_TRIES(MAX_TRIES), .CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (ev_count),
    .clear    (ev_hit | ev_recover),
    .count    (tries),
    .at_limit (at_limit)
  );

  lockout_flags u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_lock     (ev_overflow),
    .release_lock (ev_recover),
    .wipe_req     (rpw_ok),
    .zero_req     (rpw_ok),
    .grant_req    (ev_hit),
    .locked       (locked),
    .clr_arrays   (clr_arrays),
    .zero_pw      (zero_pw),
    .grant        (grant)
  );
endmodule

// File: rtl/pw_lockout_chk.sv
module pw_lockout_chk #(
  parameter int unsigned MAX_TRIES = 8,
  parameter int unsigned CW        = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pw_miss,
  input logic          pw_hit,
  input logic          rdev_ok,
  input logic [CW-1:0] tries,
  input logic          locked,
  input logic          clr_arrays,
  input logic          zero_pw,
  input logic          grant,
  input logic          ev_overflow
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && pw_miss && !pw_hit && !rdev_ok && tries < CW'(MAX_TRIES)) |=> tries == CW'($past(tries) + 1'b1)); // R1
  AST_HIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && pw_hit && !rdev_ok) |=> (tries == '0 && grant)); // R2
  AST_OVERFLOW_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overflow |=> (locked && clr_arrays && tries == CW'(MAX_TRIES))); // R3
  AST_NO_GRANT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !grant); // R4
  AST_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
    rdev_ok |=> (!locked && tries == '0)); // R6
  AST_HOLD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !rdev_ok) |=> $stable(tries)); // R8
  AST_SINGLE_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_arrays |-> (zero_pw || $rose(locked))); // R8
endmodule

bind pw_lockout_ctrl pw_lockout_chk #(.MAX_TRIES(MAX_TRIES), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pw_miss     (pw_miss),
  .pw_hit      (pw_hit),
  .rdev_ok     (rdev_ok),
  .tries       (tries),
  .locked      (locked),
  .clr_arrays  (clr_arrays),
  .zero_pw     (zero_pw),
  .grant       (grant),
  .ev_overflow (ev_overflow)
);

// File: tb/tb_pw_lockout_ctrl.sv
module tb_pw_lockout_ctrl;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned MAXT = 8;
  localparam int unsigned W = $clog2(MAXT + 1);

  typedef struct packed {
    logic [W-1:0] tries;
    logic         locked;
    logic         clr;
    logic         zpw;
    logic         grant;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pw_miss = 1'b0, pw_hit = 1'b0, rdev_ok = 1'b0, rpw_ok = 1'b0;
  logic [W-1:0] tries;
  logic locked, clr_arrays, zero_pw, grant;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  exp_t  exp_q[$];
  string tag_q[$];

  int m_tries = 0;
  bit m_lock = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pw_lockout_ctrl #(.MAX_TRIES(MAXT)) dut (
    .clk(clk), .rst_n(rst_n), .pw_miss(pw_miss), .pw_hit(pw_hit),
    .rdev_ok(rdev_ok), .rpw_ok(rpw_ok), .tries(tries), .locked(locked),
    .clr_arrays(clr_arrays), .zero_pw(zero_pw), .grant(grant)
  );

  task automatic compare(input exp_t e, input string tag);
    exp_t a;
    a = '{tries: tries, locked: locked, clr: clr_arrays, zpw: zero_pw, grant: grant};
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s: actual tries=%0d locked=%0b clr=%0b zpw=%0b grant=%0b expected tries=%0d locked=%0b clr=%0b zpw=%0b grant=%0b",
               tag, a.tries, a.locked, a.clr, a.zpw, a.grant,
               e.tries, e.locked, e.clr, e.zpw, e.grant);
    end
  endtask

  // Driver: apply one cycle of strobes and predict the outputs after the edge.
  task automatic drive(input bit miss, input bit hit, input bit rdev, input bit rpw,
                       input string tag);
    exp_t e;
    @(negedge clk);
    pw_miss = miss; pw_hit = hit; rdev_ok = rdev; rpw_ok = rpw;
    e = '0;
    e.clr = rpw;
    e.zpw = rpw;
    if (rdev) begin
      m_tries = 0; m_lock = 1'b0;
    end else if (!m_lock) begin
      if (hit) begin
        m_tries = 0; e.grant = 1'b1;
      end else if (miss) begin
        if (m_tries == MAXT) begin
          m_lock = 1'b1; e.clr = 1'b1;
        end else begin
          m_tries = m_tries + 1;
        end
      end
    end
    e.tries = W'(m_tries);
    e.locked = m_lock;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare just after each rising edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    compare('0, "R9 reset state");

    for (int i = 0; i < 3; i++) drive(1, 0, 0, 0, "R1 count miss");
    drive(0, 1, 0, 0, "R2 hit clears");
    drive(0, 0, 0, 0, "R2 grant one cycle");
    for (int i = 0; i < MAXT; i++) drive(1, 0, 0, 0, "R1 fill to limit");
    drive(0, 0, 0, 0, "R1 idle at limit");
    drive(1, 0, 0, 0, "R3 overflow lock and wipe");
    drive(0, 0, 0, 0, "R3 wipe is one cycle");
    for (int i = 0; i < 3; i++) drive(1, 0, 0, 0, "R8 miss ignored while locked");
    drive(0, 1, 0, 0, "R4 hit ignored while locked");
    drive(1, 1, 0, 0, "R4 hit and miss while locked");
    drive(0, 0, 0, 1, "R7 reset password while locked");
    drive(0, 0, 0, 0, "R7 pulse ends");
    drive(0, 0, 1, 0, "R6 recover from lock");
    drive(1, 0, 0, 0, "R6 counting resumes");
    drive(1, 0, 0, 0, "R6 counting resumes");
    drive(0, 0, 1, 0, "R5 reset device unlocked");
    drive(1, 0, 0, 0, "R1 count again");
    drive(0, 0, 0, 1, "R7 reset password unlocked");
    drive(1, 1, 0, 0, "R10 hit beats miss");
    drive(1, 0, 0, 0, "R1 count");
    drive(1, 1, 1, 0, "R10 reset device beats hit");
    for (int i = 0; i <= MAXT; i++) drive(1, 0, 0, 0, "R3 second overflow");
    drive(1, 0, 1, 0, "R10 reset device beats miss while locked");
    drive(0, 0, 0, 0, "R9 idle");
    @(negedge clk);
    pw_miss = 0; pw_hit = 0; rdev_ok = 0; rpw_ok = 0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule